// File: doc/BRIEF.md
# DRAM Row Boundary Generator

The block turns a configured memory size, given in megabytes, into eight cumulative row boundary bytes of the kind a DRAM controller decodes. It fills rows greedily. It places as many 128 MB modules as fit, then as many 32 MB modules as fit in what is left, then 8 MB modules. It works on one row per clock after a start pulse and signals completion with a one-cycle done pulse.

After allocation, software can overwrite any boundary byte through a write port. The block keeps the computed value of each row as its default. It keeps one detect flag per row, which is set when the written value differs from that default and cleared when it matches. Two pulse outputs mark the moment the flag vector leaves zero and the moment it returns to zero. The boundary bytes are read back through a combinational read port.

Top module: `dram_row_bound_gen`

## Requirements
- R1: The size in MB is rounded up to the next multiple of 8 MB before allocation (for example, 100 MB is treated as 104 MB, which is 13 units).
- R2: The rounded size is limited to 1024 MB, so a larger request gives the same boundaries as 1024 MB.
- R3: Modules are taken largest first. First come 128 MB modules, then 32 MB, then 8 MB. Each smaller size gets only the remainder left by the larger size.
- R4: Each row's boundary byte is the running total of allocated memory in 8 MB units, so a 128 MB module adds 16, a 32 MB module adds 4 and an 8 MB module adds 1. Row N is read on `rd_data` when `rd_idx` is N.
- R5: Allocation stops after the eighth row is filled, even if memory remains.
- R6: Rows left without a module hold the last running total, which is 0 when the size is 0.
- R7: Suppose `start` is sampled high while the block is idle. Then `busy` is high for the next 8 cycles. In the eighth of those cycles the last row is written, `busy` falls and `done` is high for exactly one cycle. A `start` that arrives while the block is busy has no effect.
- R8: A write with `wr_en` high while the block is idle stores `wr_data` into row `wr_idx`. The write also sets bit `wr_idx` of `detect` if the value differs from that row's computed default, and clears the bit if it equals the default. Writes made while the block is busy are dropped. An accepted start clears all detect bits.
- R9: `detect_enter` is high for one cycle in the first cycle in which `detect` is non-zero after being zero. `detect_exit` is high for one cycle in the first cycle in which `detect` is zero after being non-zero.
- R10: A synchronous reset clears all boundary bytes, defaults, detect bits, `busy`, `done` and both pulses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start an allocation (accepted when idle) |
| size_mb | input | 16 | Requested memory size in MB |
| busy | output | 1 | Allocation in progress |
| done | output | 1 | One-cycle pulse when all rows are valid |
| rd_idx | input | 3 | Row selected for reading |
| rd_data | output | 8 | Boundary byte of the selected row |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 3 | Row to overwrite |
| wr_data | input | 8 | Value to write |
| detect | output | 8 | Per-row flag: the stored value differs from the default |
| detect_enter | output | 1 | Pulse when detect leaves all-zero |
| detect_exit | output | 1 | Pulse when detect returns to all-zero |

## Verification
The hardest state to reach from the ports is a write that collides with allocation. Such a write arrives while rows are still being filled, so it must be dropped without disturbing the row that is filled in that cycle. The bench raises a write strobe in the middle of a run, aimed at a row that has not yet been filled. It then reads every row back after done and confirms the row holds its computed default and that detect stayed zero. A second start issued during the run checks that the first size still decides the result. A size of 1000 MB is used because it runs out of rows while memory is left over.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

  // Rounded-up unit count, limited to max_units.
  function automatic int unsigned size_to_units(int unsigned mb, int unsigned unit_mb,
                                                int unsigned max_units);
    int unsigned u;
    u = (mb + unit_mb - 1) / unit_mb;
    return (u > max_units) ? max_units : u;
  endfunction

  // Largest module (in units) that fits in the remaining units, or 0.
  function automatic int unsigned pick_step(int unsigned rem, int unsigned big_u,
                                            int unsigned mid_u);
    if (rem >= big_u) return big_u;
    if (rem >= mid_u) return mid_u;
    if (rem >= 1) return 1;
    return 0;
  endfunction

endpackage

// File: rtl/rbg_alloc.sv
module rbg_alloc #(
  parameter int unsigned ROWS      = 8,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned UW        = 8,
  parameter int unsigned UNIT_MB   = 8,
  parameter int unsigned BIG_U     = 16,
  parameter int unsigned MID_U     = 4,
  parameter int unsigned MAX_UNITS = 128,
  localparam int unsigned RW       = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_mb,
  output logic              busy,
  output logic              done,
  output logic              start_go,
  output logic              row_we,
  output logic [RW-1:0]     row_idx,
  output logic [UW-1:0]     row_val
);

  logic          busy_q, done_q;
  logic [RW-1:0] row_q;
  logic [UW-1:0] rem_q, acc_q;
  logic [UW-1:0] units_w, step_w;
  logic          last_row;

  assign units_w  = UW'(rbg_pkg::size_to_units(32'(size_mb), UNIT_MB, MAX_UNITS));
  assign step_w   = UW'(rbg_pkg::pick_step(32'(rem_q), BIG_U, MID_U));
  assign start_go = start && !busy_q;
  assign last_row = (row_q == RW'(ROWS - 1));
  assign row_we   = busy_q;
  assign row_idx  = row_q;
  assign row_val  = acc_q + step_w;
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_go) begin
        busy_q <= 1'b1;
        row_q  <= '0;
        rem_q  <= units_w;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= row_val;
        rem_q <= rem_q - step_w;
        row_q <= row_q + 1'b1;
        if (last_row) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Independent cycle counter for the run-length check.
  logic [RW:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || start_go) busy_cnt <= '0;
    else if (busy_q) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r7_run_length: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == (RW+1)'(ROWS)));
  a_r2_total_capped: assert property (@(posedge clk) disable iff (rst)
    done |-> (acc_q <= UW'(MAX_UNITS)));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_row) |=> busy_q);

endmodule

// File: rtl/rbg_rowfile.sv
module rbg_rowfile #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned UW   = 8,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            clr_det,
  input  logic            row_we,
  input  logic [RW-1:0]   row_idx,
  input  logic [UW-1:0]   row_val,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_idx,
  input  logic [UW-1:0]   wr_data,
  input  logic [RW-1:0]   rd_idx,
  output logic [UW-1:0]   rd_data,
  output logic [ROWS-1:0] det_q,
  output logic [ROWS-1:0] det_nxt
);

  logic [UW-1:0] bnd_q  [ROWS];
  logic [UW-1:0] dflt_q [ROWS];
  logic          wr_ok;

  assign wr_ok   = wr_en && !busy;
  assign rd_data = bnd_q[rd_idx];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      det_nxt[r] = det_q[r];
      if (clr_det) det_nxt[r] = 1'b0;
      else if (wr_ok && wr_idx == RW'(r)) det_nxt[r] = (wr_data != dflt_q[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= '0;
      for (int r = 0; r < ROWS; r++) begin
        bnd_q[r]  <= '0;
        dflt_q[r] <= '0;
      end
    end else begin
      det_q <= det_nxt;
      for (int r = 0; r < ROWS; r++) begin
        if (row_we && row_idx == RW'(r)) begin
          bnd_q[r]  <= row_val;
          dflt_q[r] <= row_val;
        end else if (wr_ok && wr_idx == RW'(r)) begin
          bnd_q[r] <= wr_data;
        end
      end
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_chk
    a_r8_flag_matches: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && !clr_det && wr_idx == RW'(g)) |=> (det_q[g] == (bnd_q[g] != dflt_q[g])));
    a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (rst)
      (busy && !(row_we && row_idx == RW'(g))) |=> $stable(bnd_q[g]));
  end

endmodule

// File: rtl/rbg_mode_edge.sv
module rbg_mode_edge #(
  parameter int unsigned ROWS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] det_q,
  input  logic [ROWS-1:0] det_nxt,
  output logic            enter,
  output logic            leave
);

  always_ff @(posedge clk) begin
    if (rst) begin
      enter <= 1'b0;
      leave <= 1'b0;
    end else begin
      enter <= (det_q == '0) && (det_nxt != '0);
      leave <= (det_q != '0) && (det_nxt == '0);
    end
  end

  a_r9_enter_edge: assert property (@(posedge clk) disable iff (rst)
    enter |-> ((det_q != '0) && ($past(det_q) == '0)));
  a_r9_exit_edge: assert property (@(posedge clk) disable iff (rst)
    leave |-> ((det_q == '0) && ($past(det_q) != '0)));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst) !(enter && leave));

endmodule

// File: rtl/dram_row_bound_gen.sv
module dram_row_bound_gen #(
  parameter int unsigned ROWS    = 8,
  parameter int unsigned SIZE_W  = 16,
  parameter int unsigned UW      = 8,
  parameter int unsigned UNIT_MB = 8,
  parameter int unsigned BIG_MB  = 128,
  parameter int unsigned MID_MB  = 32,
  parameter int unsigned MAX_MB  = 1024,
  localparam int unsigned RW        = $clog2(ROWS),
  localparam int unsigned BIG_U     = BIG_MB / UNIT_MB,
  localparam int unsigned MID_U     = MID_MB / UNIT_MB,
  localparam int unsigned MAX_UNITS = MAX_MB / UNIT_MB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_mb,
  output logic              busy,
  output logic              done,
  input  logic [RW-1:0]     rd_idx,
  output logic [UW-1:0]     rd_data,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_idx,
  input  logic [UW-1:0]     wr_data,
  output logic [ROWS-1:0]   detect,
  output logic              detect_enter,
  output logic              detect_exit
);

  logic            start_go, row_we;
  logic [RW-1:0]   row_idx;
  logic [UW-1:0]   row_val;
  logic [ROWS-1:0] det_nxt;

  rbg_alloc #(
    .ROWS(ROWS), .SIZE_W(SIZE_W), .UW(UW), .UNIT_MB(UNIT_MB),
    .BIG_U(BIG_U), .MID_U(MID_U), .MAX_UNITS(MAX_UNITS)
  ) u_alloc (
    .clk(clk), .rst(rst), .start(start), .size_mb(size_mb),
    .busy(busy), .done(done), .start_go(start_go),
    .row_we(row_we), .row_idx(row_idx), .row_val(row_val)
  );

  rbg_rowfile #(.ROWS(ROWS), .UW(UW)) u_rows (
    .clk(clk), .rst(rst), .busy(busy), .clr_det(start_go),
    .row_we(row_we), .row_idx(row_idx), .row_val(row_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .det_q(detect), .det_nxt(det_nxt)
  );

  rbg_mode_edge #(.ROWS(ROWS)) u_edge (
    .clk(clk), .rst(rst), .det_q(detect), .det_nxt(det_nxt),
    .enter(detect_enter), .leave(detect_exit)
  );

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (detect == '0 && !busy && !done && !detect_enter && !detect_exit));

endmodule

// File: tb/sim_dram_row_bound_gen.sv
module sim_dram_row_bound_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] size_mb = '0;
  logic        busy, done;
  logic [2:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  detect;
  logic        detect_enter, detect_exit;

  int checks = 0;
  int errors = 0;
  int er [8];

  always #5 clk = ~clk;

  dram_row_bound_gen u0 (
    .clk(clk), .rst(rst), .start(start), .size_mb(size_mb), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .detect(detect), .detect_enter(detect_enter), .detect_exit(detect_exit)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Tier-by-tier model of the fill.
  task automatic model(int mb);
    int u, total, row;
    int tiers [3];
    tiers[0] = 128; tiers[1] = 32; tiers[2] = 8;
    u = mb / 8 + ((mb % 8) != 0 ? 1 : 0);
    if (u > 128) u = 128;
    u = u * 8;
    total = 0; row = 0;
    for (int t = 0; t < 3; t++) begin
      int n;
      n = u / tiers[t];
      u = u % tiers[t];
      for (int k = 0; k < n; k++) begin
        if (row < 8) begin
          total += tiers[t] / 8;
          er[row] = total;
          row++;
        end
      end
    end
    for (int r = row; r < 8; r++) er[r] = total;
  endtask

  task automatic check_rows(string req);
    for (int r = 0; r < 8; r++) begin
      rd_idx = 3'(r);
      #1;
      chk(req, int'(rd_data), er[r]);
    end
  endtask

  task automatic run_alloc(int mb);
    @(negedge clk); start = 1'b1; size_mb = 16'(mb);
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sw_write(int idx, int val);
    @(negedge clk); wr_en = 1'b1; wr_idx = 3'(idx); wr_data = 8'(val);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 detect", int'(detect), 0);
    for (int r = 0; r < 8; r++) er[r] = 0;
    check_rows("R10 rows");
  endtask

  task automatic t_sizes;
    int sz [8];
    sz[0] = 1; sz[1] = 100; sz[2] = 200; sz[3] = 1024;
    sz[4] = 2000; sz[5] = 1000; sz[6] = 0; sz[7] = 64;
    for (int i = 0; i < 8; i++) begin
      run_alloc(sz[i]);
      model(sz[i]);
      check_rows($sformatf("R1 R2 R3 R4 R5 R6 size %0d", sz[i]));
    end
    // Spot values written out: 100 MB -> 13 units as 4,8,12,13,...
    run_alloc(100);
    rd_idx = 3'd3; #1; chk("R1 round-up row3", int'(rd_data), 13);
    rd_idx = 3'd7; #1; chk("R6 hold row7", int'(rd_data), 13);
    run_alloc(1000);
    rd_idx = 3'd7; #1; chk("R5 row limit row7", int'(rd_data), 116);
    run_alloc(4000);
    rd_idx = 3'd7; #1; chk("R2 clamp row7", int'(rd_data), 128);
  endtask

  task automatic t_timing;
    @(negedge clk); start = 1'b1; size_mb = 16'd200;
    @(negedge clk); start = 1'b0;
    chk("R7 busy after start", int'(busy), 1);
    chk("R7 no early done", int'(done), 0);
    repeat (3) @(negedge clk);
    start = 1'b1; size_mb = 16'd1024;
    wr_en = 1'b1; wr_idx = 3'd6; wr_data = 8'h55;
    @(negedge clk); start = 1'b0; wr_en = 1'b0;
    chk("R7 still busy", int'(busy), 1);
    repeat (3) @(negedge clk);
    chk("R7 busy cycle 8", int'(busy), 1);
    @(negedge clk);
    chk("R7 done pulse", int'(done), 1);
    chk("R7 busy falls", int'(busy), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    model(200);
    check_rows("R7 R8 start and write ignored while busy");
    chk("R8 detect untouched by busy write", int'(detect), 0);
  endtask

  task automatic t_detect;
    run_alloc(200);
    sw_write(2, 99);
    chk("R8 detect bit2 set", int'(detect), 8'h04);
    chk("R9 enter pulse", int'(detect_enter), 1);
    rd_idx = 3'd2; #1; chk("R8 readback row2", int'(rd_data), 99);
    @(negedge clk);
    chk("R9 enter one cycle", int'(detect_enter), 0);
    sw_write(5, 77);
    chk("R8 detect bits 2,5", int'(detect), 8'h24);
    chk("R9 no second enter", int'(detect_enter), 0);
    sw_write(2, 24);
    chk("R8 equal clears bit2", int'(detect), 8'h20);
    chk("R9 no early exit", int'(detect_exit), 0);
    sw_write(5, 25);
    chk("R8 detect zero", int'(detect), 0);
    chk("R9 exit pulse", int'(detect_exit), 1);
    @(negedge clk);
    chk("R9 exit one cycle", int'(detect_exit), 0);
    sw_write(0, 1);
    chk("R9 enter again", int'(detect_enter), 1);
    @(negedge clk); start = 1'b1; size_mb = 16'd64;
    @(negedge clk); start = 1'b0;
    chk("R8 start clears detect", int'(detect), 0);
    chk("R9 exit on start clear", int'(detect_exit), 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_again;
    sw_write(1, 200);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 detect after reset", int'(detect), 0);
    rd_idx = 3'd1; #1; chk("R10 row1 after reset", int'(rd_data), 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sizes();
    t_timing();
    t_detect();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule